// File: doc/BRIEF.md
# Capture Channel Input Conditioner

This block is the front end of one capture channel in a timer. It takes an asynchronous input line, brings it into the timer clock domain, and removes short glitches with a digital filter. The filter takes samples at a programmable rate and accepts a new level only after a programmed number of equal samples in a row. A single 4-bit code chooses both the sampling rate and the required run length. Each accepted level change yields a one-cycle edge pulse. A prescaler then passes on every first, second, fourth or eighth edge as a one-cycle capture strobe.

The sampling rate comes from an enable pulse. A free-running divider counts ticks of a base rate input, and no second clock domain is used. Software or the surrounding timer keeps the two codes steady while the channel runs. The channel enable clears the prescaler whenever it is low.

Top module: `cap_in_stage`

## Requirements
- R1: While reset is asserted and right after it is released, `filtLevel`, `edgePulse` and `capStrobe` are all 0.
- R2: With `filtCode` = 0 the filter is bypassed. A change on `rawIn` appears on `filtLevel` at the third rising clock edge after it: two edges for synchronization and one for the output register.
- R3: Codes 1, 2 and 3 sample on every clock and need 2, 4 and 8 equal samples. A held change appears after exactly 3+(N-1) edges.
- R4: The other codes sample once every D base ticks and need N samples. The (code: D, N) pairs are 4: 2,6; 5: 2,8; 6: 4,6; 7: 4,8; 8: 8,6; 9: 8,8; 10: 16,5; 11: 16,6; 12: 16,8; 13: 32,5; 14: 32,6; 15: 32,8. With `baseTick` held at 1, a held change appears between 3+(N-1)·D and 3+N·D-1 edges after it.
- R5: Any sample that differs from the current candidate level restarts the count. An input pulse lasting (N-1)·D cycles therefore leaves `filtLevel` unchanged and gives no edge pulse.
- R6: `edgePulse` is high for exactly one cycle, in the same cycle that `filtLevel` takes its new value, once per change.
- R7: `pscCode` values 0, 1, 2 and 3 raise `capStrobe` on every 1st, 2nd, 4th and 8th filtered edge, counted from a cleared prescaler. The strobe is one cycle wide and is always coincident with `edgePulse`.
- R8: While `chEn` is 0, `capStrobe` stays 0 and the edge count returns to zero, so edges seen before disabling do not count afterwards.
- R9: The divider advances only while `baseTick` is 1. With `baseTick` held at 0, divided-rate codes take no samples and `filtLevel` holds, while codes 0 to 3 keep working.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rstN | input | 1 | Active-low asynchronous reset |
| baseTick | input | 1 | Base-rate tick that drives the sampling divider |
| filtCode | input | 4 | Filter rate and run-length code |
| pscCode | input | 2 | Prescaler code, ratio 2^pscCode |
| chEn | input | 1 | Channel enable; when low, clears the prescaler |
| rawIn | input | 1 | Asynchronous channel input |
| filtLevel | output | 1 | Filtered input level |
| edgePulse | output | 1 | One-cycle pulse on each filtered change |
| capStrobe | output | 1 | One-cycle capture strobe after prescaling |

## Verification
Every one of the sixteen filter codes is tried with a clean held step in both directions. The measured latency is compared with the window computed from that code's rate and count, which separates a wrong run length from a wrong divider. Each non-bypass code then gets a pulse one sample too short, which shows whether the count truly restarts. Trains of sixteen edges under each prescaler code separate the four ratios, and an enable drop in the middle of a count shows that the count is cleared. A held-low base tick shows that only the divided codes depend on it.

// File: rtl/capin_pkg.sv
package capin_pkg;
  localparam int CNT_W = 4;
  localparam int DIV_W = 5;

  typedef struct packed {
    logic             sampleEn;
    logic [CNT_W-1:0] needCnt;
  } ctrlStrobes_t;
endpackage

// File: rtl/capin_ctrl.sv
module capin_ctrl
  import capin_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         baseTick,
  input  logic [3:0]   filtCode,
  output ctrlStrobes_t strobes
);
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divMax;
  logic             timerRate;
  logic [2:0]       divExp;
  logic [CNT_W-1:0] need;

  always_comb begin
    timerRate = 1'b0;
    divExp    = 3'd1;
    need      = CNT_W'(1);
    unique case (filtCode)
      4'd0:  begin timerRate = 1'b1; need = CNT_W'(1); end
      4'd1:  begin timerRate = 1'b1; need = CNT_W'(2); end
      4'd2:  begin timerRate = 1'b1; need = CNT_W'(4); end
      4'd3:  begin timerRate = 1'b1; need = CNT_W'(8); end
      4'd4:  begin divExp = 3'd1; need = CNT_W'(6); end
      4'd5:  begin divExp = 3'd1; need = CNT_W'(8); end
      4'd6:  begin divExp = 3'd2; need = CNT_W'(6); end
      4'd7:  begin divExp = 3'd2; need = CNT_W'(8); end
      4'd8:  begin divExp = 3'd3; need = CNT_W'(6); end
      4'd9:  begin divExp = 3'd3; need = CNT_W'(8); end
      4'd10: begin divExp = 3'd4; need = CNT_W'(5); end
      4'd11: begin divExp = 3'd4; need = CNT_W'(6); end
      4'd12: begin divExp = 3'd4; need = CNT_W'(8); end
      4'd13: begin divExp = 3'd5; need = CNT_W'(5); end
      4'd14: begin divExp = 3'd5; need = CNT_W'(6); end
      default: begin divExp = 3'd5; need = CNT_W'(8); end
    endcase
    divMax = DIV_W'((32'd1 << divExp) - 32'd1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (baseTick) begin
      divCnt <= (divCnt >= divMax) ? '0 : divCnt + 1'b1;
    end
  end

  always_comb begin
    strobes.needCnt  = need;
    strobes.sampleEn = timerRate | (baseTick & (divCnt >= divMax));
  end
endmodule

// File: rtl/capin_datapath.sv
module capin_datapath
  import capin_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PSC_W       = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic [PSC_W-1:0] pscCode,
  input  logic             chEn,
  input  logic             rawIn,
  output logic             filtLevel,
  output logic             edgePulse,
  output logic             capStrobe
);
  localparam int PS_MAX = (1 << ((1 << PSC_W) - 1)) - 1;
  localparam int PS_W   = $clog2(PS_MAX + 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   sampleIn;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : gSync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[g] <= 1'b0;
        else if (g == 0) syncQ[g] <= rawIn;
        else syncQ[g] <= syncQ[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate
  assign sampleIn = syncQ[SYNC_STAGES-1];

  logic             cand, candNext;
  logic [CNT_W-1:0] runCnt, runNext;
  logic             levelNext, levelChg;

  always_comb begin
    candNext  = cand;
    runNext   = runCnt;
    levelNext = filtLevel;
    if (strobes.sampleEn) begin
      if (sampleIn == cand) begin
        runNext = (runCnt >= strobes.needCnt) ? runCnt : runCnt + 1'b1;
      end else begin
        candNext = sampleIn;
        runNext  = CNT_W'(1);
      end
      if (runNext >= strobes.needCnt) levelNext = candNext;
    end
    levelChg = levelNext != filtLevel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cand      <= 1'b0;
      runCnt    <= '0;
      filtLevel <= 1'b0;
      edgePulse <= 1'b0;
    end else begin
      cand      <= candNext;
      runCnt    <= runNext;
      filtLevel <= levelNext;
      edgePulse <= levelChg;
    end
  end

  logic [PS_W-1:0] psCnt;
  logic [PS_W-1:0] psMask;
  assign psMask = PS_W'((32'd1 << pscCode) - 32'd1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      psCnt     <= '0;
      capStrobe <= 1'b0;
    end else if (!chEn) begin
      psCnt     <= '0;
      capStrobe <= 1'b0;
    end else if (levelChg) begin
      if (psCnt >= psMask) begin
        psCnt     <= '0;
        capStrobe <= 1'b1;
      end else begin
        psCnt     <= psCnt + 1'b1;
        capStrobe <= 1'b0;
      end
    end else begin
      capStrobe <= 1'b0;
    end
  end
endmodule

// File: rtl/cap_in_stage.sv
module cap_in_stage
  import capin_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       baseTick,
  input  logic [3:0] filtCode,
  input  logic [1:0] pscCode,
  input  logic       chEn,
  input  logic       rawIn,
  output logic       filtLevel,
  output logic       edgePulse,
  output logic       capStrobe
);
  ctrlStrobes_t strobes;

  capin_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .baseTick (baseTick),
    .filtCode (filtCode),
    .strobes  (strobes)
  );

  capin_datapath #(.SYNC_STAGES(2), .PSC_W(2)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .pscCode   (pscCode),
    .chEn      (chEn),
    .rawIn     (rawIn),
    .filtLevel (filtLevel),
    .edgePulse (edgePulse),
    .capStrobe (capStrobe)
  );
endmodule

// File: rtl/capin_checker.sv
module capin_checker (
  input logic       clk,
  input logic       rstN,
  input logic       rawIn,
  input logic       chEn,
  input logic [1:0] pscCode,
  input logic       filtLevel,
  input logic       edgePulse,
  input logic       capStrobe
);
  logic [2:0] sinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceRst <= '0;
    else if (sinceRst != 3'd7) sinceRst <= sinceRst + 1'b1;
  end

  // R1: outputs stay quiet while reset is applied
  always @(posedge clk) begin
    if (!rstN) begin
      assert_reset_quiet_R1: assert (!edgePulse && !capStrobe);
    end
  end

  // R6: every filtered change is accompanied by the edge pulse
  assert_edge_marks_change_R6: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 3'd2 && !$stable(filtLevel)) |-> edgePulse);

  // R2 R3 R4: an accepted level equals the input seen three clocks earlier
  assert_level_from_input_R3: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 3'd5 && !$stable(filtLevel)) |-> ($past(rawIn, 3) == filtLevel));

  // R7: a capture strobe only occurs on a filtered edge
  assert_strobe_on_edge_R7: assert property (@(posedge clk) disable iff (!rstN)
    capStrobe |-> edgePulse);

  // R7: with ratio 1 every edge captures while enabled
  assert_ratio_one_R7: assert property (@(posedge clk) disable iff (!rstN)
    (edgePulse && $past(chEn) && chEn && $past(pscCode) == 2'd0) |-> capStrobe);

  // R8: disabled channel never strobes on the next cycle
  assert_disabled_silent_R8: assert property (@(posedge clk) disable iff (!rstN)
    !chEn |=> !capStrobe);
endmodule

bind cap_in_stage capin_checker i_capin_checker (
  .clk       (clk),
  .rstN      (rstN),
  .rawIn     (rawIn),
  .chEn      (chEn),
  .pscCode   (pscCode),
  .filtLevel (filtLevel),
  .edgePulse (edgePulse),
  .capStrobe (capStrobe)
);

// File: tb/test_cap_in_stage.sv
`timescale 1ns/1ps
module test_cap_in_stage;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baseTick = 1'b1;
  logic [3:0] filtCode = 4'd0;
  logic [1:0] pscCode = 2'd0;
  logic       chEn = 1'b1;
  logic       rawIn = 1'b0;
  logic       filtLevel, edgePulse, capStrobe;

  int checks = 0;
  int fails  = 0;
  int epCount = 0;
  int capCount = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cap_in_stage i_cap_in_stage (
    .clk(clk), .rstN(rstN), .baseTick(baseTick), .filtCode(filtCode),
    .pscCode(pscCode), .chEn(chEn), .rawIn(rawIn),
    .filtLevel(filtLevel), .edgePulse(edgePulse), .capStrobe(capStrobe)
  );

  always @(negedge clk) begin
    if (edgePulse) epCount++;
    if (capStrobe) capCount++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int needOf(input int code);
    int t[16] = '{1,2,4,8,6,8,6,8,6,8,5,6,8,5,6,8};
    return t[code];
  endfunction

  function automatic int divOf(input int code);
    if (code < 4) return 1;
    if (code < 6) return 2;
    if (code < 8) return 4;
    if (code < 10) return 8;
    if (code < 13) return 16;
    return 32;
  endfunction

  // step the input and measure edges until the filtered level follows
  task automatic stepLat(input int code, input string req);
    int n = needOf(code);
    int d = divOf(code);
    int lo = 3 + (n - 1) * d;
    int hi = lo + d - 1;
    int lat = 0;
    int ep0;
    bit target;
    filtCode = 4'(code);
    repeat (n * d + 2 * d + 8) @(posedge clk);
    @(negedge clk);
    target = ~rawIn;
    rawIn = target;
    ep0 = epCount;
    for (int k = 1; k <= 400; k++) begin
      @(posedge clk); #1;
      if (filtLevel == target) begin lat = k; break; end
    end
    check(lat >= lo && lat <= hi, req, lat, lo);
    check(edgePulse == 1'b1, "R6 pulse with change", int'(edgePulse), 1);
    repeat (4) @(posedge clk);
    #1;
    check(epCount - ep0 == 1, "R6 single pulse", epCount - ep0, 1);
  endtask

  task automatic glitch(input int code);
    int n = needOf(code);
    int d = divOf(code);
    int ep0;
    bit lvl;
    filtCode = 4'(code);
    repeat (n * d + 2 * d + 8) @(posedge clk);
    #1;
    lvl = filtLevel;
    ep0 = epCount;
    @(negedge clk);
    rawIn = ~lvl;
    repeat ((n - 1) * d) @(negedge clk);
    rawIn = lvl;
    repeat (n * d + 2 * d + 8) @(posedge clk);
    #1;
    check(filtLevel == lvl && epCount == ep0, "R5 short pulse rejected",
          epCount - ep0, 0);
  endtask

  task automatic toggleIn();
    @(negedge clk);
    rawIn = ~rawIn;
    repeat (6) @(posedge clk);
  endtask

  task automatic clearPsc();
    @(negedge clk); chEn = 1'b0;
    repeat (2) @(negedge clk);
    chEn = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int c0;
    repeat (3) @(posedge clk);
    #1;
    check(!filtLevel && !edgePulse && !capStrobe, "R1 in reset",
          int'({filtLevel, edgePulse, capStrobe}), 0);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    check(!filtLevel && !edgePulse && !capStrobe, "R1 after release",
          int'({filtLevel, edgePulse, capStrobe}), 0);

    // R2 bypass, both directions
    stepLat(0, "R2 bypass rise");
    stepLat(0, "R2 bypass fall");
    // R3 timer-rate codes
    for (int c = 1; c <= 3; c++) begin
      stepLat(c, "R3 timer rate rise");
      stepLat(c, "R3 timer rate fall");
    end
    // R4 divided codes
    for (int c = 4; c <= 15; c++) begin
      stepLat(c, "R4 divided rate rise");
      stepLat(c, "R4 divided rate fall");
    end
    // R5 glitch rejection for every filtering code
    for (int c = 1; c <= 15; c++) glitch(c);

    // R7 prescaler ratios
    filtCode = 4'd0;
    for (int p = 0; p < 4; p++) begin
      pscCode = 2'(p);
      clearPsc();
      repeat (4) @(posedge clk);
      c0 = capCount;
      for (int e = 0; e < 16; e++) toggleIn();
      check(capCount - c0 == (16 >> p), "R7 prescaler ratio", capCount - c0, 16 >> p);
    end

    // R8 enable clears count
    pscCode = 2'd1;
    clearPsc();
    repeat (4) @(posedge clk);
    c0 = capCount;
    toggleIn();
    clearPsc();
    repeat (4) @(posedge clk);
    toggleIn();
    check(capCount == c0, "R8 count cleared by disable", capCount - c0, 0);
    toggleIn();
    check(capCount - c0 == 1, "R8 count resumes", capCount - c0, 1);
    @(negedge clk); chEn = 1'b0;
    c0 = capCount;
    pscCode = 2'd0;
    for (int e = 0; e < 4; e++) toggleIn();
    check(capCount == c0, "R8 no strobe while disabled", capCount - c0, 0);
    @(negedge clk); chEn = 1'b1;

    // R9 base tick held low
    @(negedge clk); baseTick = 1'b0;
    filtCode = 4'd4;
    repeat (20) @(posedge clk);
    #1;
    c0 = int'(filtLevel);
    @(negedge clk); rawIn = ~filtLevel;
    repeat (100) @(posedge clk);
    #1;
    check(int'(filtLevel) == c0, "R9 no samples without tick", int'(filtLevel), c0);
    @(negedge clk); baseTick = 1'b1;
    repeat (40) @(posedge clk);
    #1;
    check(filtLevel == rawIn, "R9 resumes with tick", int'(filtLevel), int'(rawIn));
    @(negedge clk); baseTick = 1'b0;
    filtCode = 4'd1;
    repeat (10) @(posedge clk);
    @(negedge clk); rawIn = ~rawIn;
    repeat (4) @(posedge clk);
    #1;
    check(filtLevel == rawIn, "R9 timer rate ignores tick", int'(filtLevel), int'(rawIn));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule